// File: doc/BRIEF.md
# Double-to-Single Rounding Unit

This block accepts an unrounded value in 64-bit IEEE-754 double format. It rounds that value to the range and precision of single format, using one of four rounding modes. It returns the rounded value twice: as a 32-bit single image, and widened back into a 64-bit double encoding. A fused arithmetic datapath can use it as its last stage when the result is single precision but the register file holds doubles.

A negate-after-round control flips the sign of both images. The flip happens only after rounding, so the directed modes use the sign the value had on entry. The block also reports four flags: overflow, underflow, inexact, and increment. Increment means the magnitude grew away from truncation. The logic is combinational. An optional output register stage is selected by the parameter `OUT_REG`, which defaults to 1.

Top module: `dp2sp_rounder`

## Requirements
- R1: With `rmode` = 2'b00, rounding is to nearest. A tie rounds to the even single mantissa.
- R2: With `rmode` = 2'b01, rounding is toward zero. Discarded bits are dropped and the magnitude never grows.
- R3: `rmode` = 2'b10 rounds toward +infinity and 2'b11 rounds toward -infinity. Both use the sign of `din`.
- R4: When `neg_after` is 1, bit 31 of `dout32` and bit 63 of `dout64` are inverted after rounding. The flags are unchanged.
- R5: A finite result whose biased single exponent would exceed 254 sets both `ovf` and `inexact`. The result is infinity in mode 00, in mode 10 for positive values, and in mode 11 for negative values. In the other cases the result is the largest finite single, 0x7F7FFFFF with the sign applied.
- R6: A value below 2^-126 before rounding is shifted into the single subnormal range and then rounded. `unf` is set only when such a value is also inexact. An exact tiny value sets no flag.
- R7: A NaN input produces a quiet NaN. Bit 22 of the single fraction is set, and bits 21..0 take double fraction bits 50..29. No flag is set.
- R8: Infinities and zeros pass through unchanged, with their sign, and set no flag.
- R9: `dout64` is always the exact double encoding of `dout32`. Subnormal singles are normalized into the double.
- R10: `incr` is 1 exactly when the result magnitude exceeds the truncated magnitude. This includes a carry that raises the exponent and an overflow to infinity. `incr` implies `inexact`.
- R11: With `OUT_REG` = 1, results appear one clock after their inputs, and synchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 64 | Unrounded double-format value |
| rmode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| neg_after | input | 1 | Invert the sign of the rounded result |
| dout64 | output | 64 | Rounded result in double encoding |
| dout32 | output | 32 | Rounded result in single encoding |
| ovf | output | 1 | Overflow flag |
| unf | output | 1 | Underflow flag (tiny and inexact) |
| inexact | output | 1 | Result differs from input |
| incr | output | 1 | Magnitude rounded away from truncation |

## Verification
The hardest paths to reach are the ones where rounding itself changes the class of the result. One is a tiny value that rounds up into the smallest normal. Another is a value just under the single limit that carries into overflow. A third is a double subnormal that collapses into the sticky bit of a maximal shift. The stimulus table builds these from exact bit patterns: 0x380FFFFFFFFFFFFF, 0x47EFFFFFFFFFFFFF and 0x0000000000000001. Each of them is paired with modes that decide whether the magnitude grows. Inputs are also chosen so that negation-after-round gives a different answer from negation-before-round.

// File: rtl/dsr_pkg.sv
`timescale 1ns/1ps
package dsr_pkg;
    localparam int DW     = 64;
    localparam int SW     = 32;
    localparam int DFRAC  = 52;
    localparam int SFRAC  = 23;
    localparam int DBIAS  = 1023;
    localparam int SBIAS  = 127;
    localparam int SIGW   = DFRAC + 1;          // 53 significand bits
    localparam int KEEPW  = SFRAC + 1;          // 24 kept bits
    localparam int PLW    = SFRAC - 1;          // NaN payload carried
    localparam int SHMAX  = 60;                 // shift cap, beyond = sticky
    localparam int WIDEW  = SIGW + 64;
    localparam int EW     = 13;                 // signed unbiased exponent width
    localparam int EMIN_S = 1 - SBIAS;          // -126

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        CL_ZERO,
        CL_FIN,
        CL_INF,
        CL_NAN
    } dclass_e;

    typedef struct packed {
        logic                 sign;
        dclass_e              cls;
        logic signed [EW-1:0] uexp;
        logic [SIGW-1:0]      sig;
        logic [PLW-1:0]       nan_pl;
    } dunpk_t;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic inx;
        logic inc;
    } rflags_t;

    function automatic logic rnd_up(input rmode_e m, input logic sign,
                                    input logic lsb, input logic rb, input logic sb);
        case (m)
            RM_NEAR: rnd_up = rb & (sb | lsb);
            RM_ZERO: rnd_up = 1'b0;
            RM_UP:   rnd_up = (rb | sb) & ~sign;
            default: rnd_up = (rb | sb) & sign;
        endcase
    endfunction

    function automatic logic [DW-1:0] sp_to_dp(input logic [SW-1:0] s);
        logic [7:0]        e;
        logic [SFRAC-1:0]  m;
        logic [SIGW-1:0]   t;
        int                p;
        e = s[30:23];
        m = s[SFRAC-1:0];
        p = 0;
        t = '0;
        if (e == 8'hFF)
            sp_to_dp = {s[31], 11'h7FF, m, 29'b0};
        else if (e == 8'h00 && m == '0)
            sp_to_dp = {s[31], 63'b0};
        else if (e == 8'h00) begin
            for (int i = 0; i < SFRAC; i++)
                if (m[i]) p = i;
            t = {30'b0, m} << (DFRAC - p);
            sp_to_dp = {s[31], 11'(p + DBIAS - SBIAS - SFRAC + 1), t[DFRAC-1:0]};
        end else
            sp_to_dp = {s[31], 11'({3'b0, e} + 11'(DBIAS - SBIAS)), m, 29'b0};
    endfunction
endpackage

// File: rtl/dsr_unpack.sv
`timescale 1ns/1ps
module dsr_unpack
    import dsr_pkg::*;
(
    input  logic [DW-1:0] din,
    output dunpk_t        unp
);
    logic [10:0]      ex;
    logic [DFRAC-1:0] fr;

    assign ex = din[62:52];
    assign fr = din[DFRAC-1:0];

    always_comb begin
        unp.sign   = din[63];
        unp.nan_pl = fr[50:29];
        unp.sig    = {ex != 11'd0, fr};
        unp.uexp   = (ex == 11'd0) ? EW'(1 - DBIAS) : EW'({2'b0, ex}) - EW'(DBIAS);
        if (ex == 11'h7FF)
            unp.cls = (fr != '0) ? CL_NAN : CL_INF;
        else if (ex == 11'd0 && fr == '0)
            unp.cls = CL_ZERO;
        else
            unp.cls = CL_FIN;
    end
endmodule

// File: rtl/dsr_round.sv
`timescale 1ns/1ps
module dsr_round
    import dsr_pkg::*;
(
    input  dunpk_t         unp,
    input  rmode_e         mode,
    output logic [SW-1:0]  sp,
    output rflags_t        flg
);
    logic                 tiny;
    logic signed [EW-1:0] sh_raw;
    logic [6:0]           sh;
    logic [WIDEW-1:0]     wide;
    logic [KEEPW-1:0]     kept;
    logic                 rb, sb, inc, carry, ovf, to_inf;
    logic [KEEPW:0]       sum;
    logic signed [EW-1:0] enew;

    assign tiny   = unp.uexp < EW'(EMIN_S);
    assign sh_raw = EW'(EMIN_S) - unp.uexp;
    assign sh     = !tiny ? 7'd0 : (sh_raw > EW'(SHMAX)) ? 7'(SHMAX) : sh_raw[6:0];
    assign wide   = {unp.sig, 64'b0} >> sh;
    assign kept   = wide[WIDEW-1 -: KEEPW];
    assign rb     = wide[WIDEW-1-KEEPW];
    assign sb     = |wide[WIDEW-2-KEEPW:0];
    assign inc    = rnd_up(mode, unp.sign, kept[0], rb, sb);
    assign sum    = {1'b0, kept} + {{KEEPW{1'b0}}, inc};
    assign carry  = sum[KEEPW];
    assign enew   = unp.uexp + EW'(SBIAS) + $signed({{(EW-1){1'b0}}, carry});
    assign ovf    = !tiny && (enew > EW'(254));
    assign to_inf = (mode == RM_NEAR) || (mode == RM_UP && !unp.sign) ||
                    (mode == RM_DOWN && unp.sign);

    always_comb begin
        flg = '0;
        case (unp.cls)
            CL_NAN:  sp = {unp.sign, 8'hFF, 1'b1, unp.nan_pl};
            CL_INF:  sp = {unp.sign, 8'hFF, 23'b0};
            CL_ZERO: sp = {unp.sign, 31'b0};
            default: begin
                if (ovf) begin
                    sp      = to_inf ? {unp.sign, 8'hFF, 23'b0} : {unp.sign, 8'hFE, 23'h7FFFFF};
                    flg.ovf = 1'b1;
                    flg.inx = 1'b1;
                    flg.inc = to_inf;
                end else if (tiny) begin
                    sp      = {unp.sign, 7'b0, sum[SFRAC], sum[SFRAC-1:0]};
                    flg.inx = rb | sb;
                    flg.unf = rb | sb;
                    flg.inc = inc;
                end else begin
                    sp      = {unp.sign, enew[7:0], sum[SFRAC-1:0]};
                    flg.inx = rb | sb;
                    flg.inc = inc;
                end
            end
        endcase
    end
endmodule

// File: rtl/dsr_expand.sv
`timescale 1ns/1ps
module dsr_expand
    import dsr_pkg::*;
(
    input  logic [SW-1:0] sp,
    input  logic          neg,
    output logic [SW-1:0] res32,
    output logic [DW-1:0] res64
);
    logic [DW-1:0] wide_d;

    assign wide_d = sp_to_dp(sp);
    assign res32  = {sp[SW-1] ^ neg, sp[SW-2:0]};
    assign res64  = {wide_d[DW-1] ^ neg, wide_d[DW-2:0]};
endmodule

// File: rtl/dp2sp_rounder.sv
`timescale 1ns/1ps
module dp2sp_rounder
    import dsr_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [63:0]   din,
    input  logic [1:0]    rmode,
    input  logic          neg_after,
    output logic [63:0]   dout64,
    output logic [31:0]   dout32,
    output logic          ovf,
    output logic          unf,
    output logic          inexact,
    output logic          incr
);
    dunpk_t        unp;
    logic [SW-1:0] sp;
    rflags_t       flg;
    logic [SW-1:0] c32;
    logic [DW-1:0] c64;

    dsr_unpack u_unpack (.din(din), .unp(unp));
    dsr_round  u_round  (.unp(unp), .mode(rmode_e'(rmode)), .sp(sp), .flg(flg));
    dsr_expand u_expand (.sp(sp), .neg(neg_after), .res32(c32), .res64(c64));

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    dout64  <= '0;
                    dout32  <= '0;
                    ovf     <= 1'b0;
                    unf     <= 1'b0;
                    inexact <= 1'b0;
                    incr    <= 1'b0;
                end else begin
                    dout64  <= c64;
                    dout32  <= c32;
                    ovf     <= flg.ovf;
                    unf     <= flg.unf;
                    inexact <= flg.inx;
                    incr    <= flg.inc;
                end
            end
        end else begin : g_comb
            always_comb begin
                dout64  = c64;
                dout32  = c32;
                ovf     = flg.ovf;
                unf     = flg.unf;
                inexact = flg.inx;
                incr    = flg.inc;
            end
        end
    endgenerate
endmodule

// File: rtl/dsr_chk.sv
`timescale 1ns/1ps
module dsr_chk #(
    parameter bit OUT_REG = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic [63:0] din,
    input logic [63:0] dout64,
    input logic [31:0] dout32,
    input logic        ovf,
    input logic        unf,
    input logic        inexact,
    input logic        incr
);
    p_ovf_inexact_r5: assert property (@(posedge clk) disable iff (rst)
        ovf |-> inexact);
    p_ovf_exp_r5: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (dout32[30:24] == 7'h7F));
    p_unf_inexact_r6: assert property (@(posedge clk) disable iff (rst)
        unf |-> inexact);
    p_inc_inexact_r10: assert property (@(posedge clk) disable iff (rst)
        incr |-> inexact);
    p_sign_agree_r9: assert property (@(posedge clk) disable iff (rst)
        dout64[63] == dout32[31]);
    p_special_exp_r9: assert property (@(posedge clk) disable iff (rst)
        (dout32[30:23] == 8'hFF) |-> (dout64[62:52] == 11'h7FF));

    generate
        if (OUT_REG) begin : g_seq
            p_nan_quiet_r7: assert property (@(posedge clk) disable iff (rst)
                (din[62:52] == 11'h7FF && din[51:0] != 52'd0) |=>
                (dout32[30:22] == 9'h1FF && !ovf && !unf && !inexact && !incr));
            p_inf_clean_r8: assert property (@(posedge clk) disable iff (rst)
                (din[62:0] == {11'h7FF, 52'd0}) |=>
                (dout32[30:0] == {8'hFF, 23'd0} && !inexact));
        end
    endgenerate
endmodule

bind dp2sp_rounder dsr_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk(clk), .rst(rst), .din(din), .dout64(dout64), .dout32(dout32),
    .ovf(ovf), .unf(unf), .inexact(inexact), .incr(incr)
);

// File: tb/dp2sp_rounder_bench.sv
`timescale 1ns/1ps
module dp2sp_rounder_bench;
    typedef struct packed {
        logic [63:0] din;
        logic [1:0]  rm;
        logic        ng;
        logic [31:0] e32;
        logic [63:0] e64;
        logic [3:0]  fl;   // {ovf, unf, inexact, incr}
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{64'h3FF0000000000000, 2'd0, 1'b0, 32'h3F800000, 64'h3FF0000000000000, 4'b0000, 8'd1},  // R1 exact
        '{64'h3FF0000010000000, 2'd0, 1'b0, 32'h3F800000, 64'h3FF0000000000000, 4'b0010, 8'd1},  // R1 tie to even (down)
        '{64'h3FF0000010000001, 2'd0, 1'b0, 32'h3F800001, 64'h3FF0000020000000, 4'b0011, 8'd1},  // R1 above half
        '{64'h3FF0000030000000, 2'd0, 1'b0, 32'h3F800002, 64'h3FF0000040000000, 4'b0011, 8'd1},  // R1 tie to even (up)
        '{64'h3FB999999999999A, 2'd1, 1'b0, 32'h3DCCCCCC, 64'h3FB9999980000000, 4'b0010, 8'd2},  // R2
        '{64'h3FF0000030000000, 2'd1, 1'b0, 32'h3F800001, 64'h3FF0000020000000, 4'b0010, 8'd2},  // R2
        '{64'h3FF0000010000000, 2'd2, 1'b0, 32'h3F800001, 64'h3FF0000020000000, 4'b0011, 8'd3},  // R3 up, positive
        '{64'hBFF0000010000001, 2'd3, 1'b0, 32'hBF800001, 64'hBFF0000020000000, 4'b0011, 8'd3},  // R3 down, negative
        '{64'hBFF0000010000001, 2'd2, 1'b0, 32'hBF800000, 64'hBFF0000000000000, 4'b0010, 8'd3},  // R3 up, negative
        '{64'h3FF0000010000001, 2'd2, 1'b1, 32'hBF800001, 64'hBFF0000020000000, 4'b0011, 8'd4},  // R4 sign used is pre-negation
        '{64'h3FF0000010000001, 2'd3, 1'b1, 32'hBF800000, 64'hBFF0000000000000, 4'b0010, 8'd4},  // R4
        '{64'h3FF0000000000000, 2'd0, 1'b1, 32'hBF800000, 64'hBFF0000000000000, 4'b0000, 8'd4},  // R4 exact
        '{64'h47F0000000000000, 2'd0, 1'b0, 32'h7F800000, 64'h7FF0000000000000, 4'b1011, 8'd5},  // R5 to inf
        '{64'h47F0000000000000, 2'd1, 1'b0, 32'h7F7FFFFF, 64'h47EFFFFFE0000000, 4'b1010, 8'd5},  // R5 to max
        '{64'hC7F0000000000000, 2'd2, 1'b0, 32'hFF7FFFFF, 64'hC7EFFFFFE0000000, 4'b1010, 8'd5},  // R5
        '{64'hC7F0000000000000, 2'd3, 1'b0, 32'hFF800000, 64'hFFF0000000000000, 4'b1011, 8'd5},  // R5
        '{64'h47EFFFFFFFFFFFFF, 2'd0, 1'b0, 32'h7F800000, 64'h7FF0000000000000, 4'b1011, 8'd5},  // R5 carry into overflow
        '{64'h3FFFFFFFFFFFFFFF, 2'd0, 1'b0, 32'h40000000, 64'h4000000000000000, 4'b0011, 8'd10}, // R10 carry bumps exponent
        '{64'h36A0000000000000, 2'd0, 1'b0, 32'h00000001, 64'h36A0000000000000, 4'b0000, 8'd6},  // R6 exact tiny
        '{64'h3690000000000000, 2'd0, 1'b0, 32'h00000000, 64'h0000000000000000, 4'b0110, 8'd6},  // R6
        '{64'h3690000000000000, 2'd2, 1'b0, 32'h00000001, 64'h36A0000000000000, 4'b0111, 8'd6},  // R6
        '{64'h36A8000000000000, 2'd0, 1'b0, 32'h00000002, 64'h36B0000000000000, 4'b0111, 8'd6},  // R6
        '{64'h380FFFFFFFFFFFFF, 2'd0, 1'b0, 32'h00800000, 64'h3810000000000000, 4'b0111, 8'd6},  // R6 tiny to min normal
        '{64'h0000000000000001, 2'd2, 1'b0, 32'h00000001, 64'h36A0000000000000, 4'b0111, 8'd6},  // R6 double subnormal
        '{64'h0000000000000001, 2'd0, 1'b0, 32'h00000000, 64'h0000000000000000, 4'b0110, 8'd6},  // R6
        '{64'h36B8000000000000, 2'd0, 1'b0, 32'h00000003, 64'h36B8000000000000, 4'b0000, 8'd9},  // R9 subnormal widened
        '{64'h7FF0000000000001, 2'd0, 1'b0, 32'h7FC00000, 64'h7FF8000000000000, 4'b0000, 8'd7},  // R7
        '{64'h7FF4000020000000, 2'd1, 1'b0, 32'h7FE00001, 64'h7FFC000020000000, 4'b0000, 8'd7},  // R7 payload
        '{64'hFFF0000000000000, 2'd2, 1'b0, 32'hFF800000, 64'hFFF0000000000000, 4'b0000, 8'd8},  // R8
        '{64'h8000000000000000, 2'd0, 1'b1, 32'h00000000, 64'h0000000000000000, 4'b0000, 8'd8},  // R8
        '{64'h3FB999999999999A, 2'd0, 1'b0, 32'h3DCCCCCD, 64'h3FB99999A0000000, 4'b0011, 8'd10}, // R10
        '{64'h8000000000000001, 2'd3, 1'b0, 32'h80000001, 64'hB6A0000000000000, 4'b0111, 8'd3}   // R3 negative tiny
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] din = '0;
    logic [1:0]  rmode = '0;
    logic        neg_after = 1'b0;
    logic [63:0] dout64;
    logic [31:0] dout32;
    logic        ovf, unf, inexact, incr;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    dp2sp_rounder u_dp2sp_rounder (
        .clk(clk), .rst(rst), .din(din), .rmode(rmode), .neg_after(neg_after),
        .dout64(dout64), .dout32(dout32), .ovf(ovf), .unf(unf),
        .inexact(inexact), .incr(incr)
    );

    task automatic expect_all(input int rq, input logic [31:0] e32,
                              input logic [63:0] e64, input logic [3:0] fl);
        checks++;
        if (dout32 !== e32) begin
            errors++;
            $display("FAIL R%0d dout32 actual=%h expected=%h", rq, dout32, e32);
        end
        checks++;
        if (dout64 !== e64) begin
            errors++;
            $display("FAIL R%0d dout64 actual=%h expected=%h", rq, dout64, e64);
        end
        checks++;
        if ({ovf, unf, inexact, incr} !== fl) begin
            errors++;
            $display("FAIL R%0d flags actual=%b expected=%b", rq, {ovf, unf, inexact, incr}, fl);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        expect_all(11, 32'h0, 64'h0, 4'b0000);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            din = VECS[i].din; rmode = VECS[i].rm; neg_after = VECS[i].ng;
            @(negedge clk);
            expect_all(int'(VECS[i].rq), VECS[i].e32, VECS[i].e64, VECS[i].fl);
        end
        // R11: one-cycle latency; new input not yet visible before the edge
        @(negedge clk);
        din = 64'h47F0000000000000; rmode = 2'd0; neg_after = 1'b0;
        @(negedge clk);
        din = 64'h3FF0000000000000;
        #1;
        expect_all(11, 32'h7F800000, 64'h7FF0000000000000, 4'b1011);
        @(negedge clk);
        expect_all(11, 32'h3F800000, 64'h3FF0000000000000, 4'b0000);
        // R11: synchronous reset clears outputs
        rst = 1'b1;
        @(negedge clk);
        expect_all(11, 32'h0, 64'h0, 4'b0000);
        rst = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule